// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static RAM with an 18-bit word made of two 9-bit byte lanes. Address and control are registered on the rising clock edge. Read data comes out of a registered output stage one enabled edge after the address is captured. Write data follows its address by two enabled edges. Because of this late write, the bus can switch between reads and writes every cycle with no idle cycle in between.

A write stays pending in the pipeline until its data arrives. If a read targets an address whose write has not yet reached the array, the read returns the write data in the lanes being written. The other lanes come from the array. Each cycle loads a new operation from the address bus, or continues a short burst from a 2-bit wrap-around counter. An active-low clock enable freezes the whole pipeline.

Top module: `zbt_sram`

## Requirements
- R1: After asynchronous reset (`rst_ni` low), `valid_o` is 0 and `rdata_o` is all zeros.
- R2: A selected read loaded at enabled edge k presents the word at its address on `rdata_o`, with `valid_o` high, from edge k+1 until the next enabled edge. `valid_o` is low after every enabled edge whose preceding cycle did not carry a read.
- R3: A selected write loaded at enabled edge k takes its data from `wdata_i` as sampled at enabled edge k+2. It stores that data at its address.
- R4: Byte lane i is bits [9i+8:9i]. It is written only if `bw_ni[i]` is 0 on the edge that captures the operation. A lane whose bit is 1 keeps its stored value.
- R5: Reads and writes may alternate on consecutive enabled edges with no idle cycle, and every transfer completes correctly.
- R6: A read loaded one enabled edge after a write to the same address returns the write's data in the lanes that write enables. The remaining lanes come from the stored word.
- R7: While `cke_ni` is 1, all other inputs are ignored, and `rdata_o`, `valid_o` and all pipeline state hold their values.
- R8: A load cycle (`adv_i` = 0) selects the device only when `sel_a_ni` = 0, `sel_b_i` = 1 and `sel_c_ni` = 0. Otherwise the cycle is a deselect: nothing is written and no read data is presented.
- R9: With `adv_i` = 1, the previous cycle's operation (read, write or deselect) repeats at an address whose two low bits are incremented modulo 4, with the upper bits unchanged. On such cycles `we_ni`, `addr_i` and the chip enables are ignored. `bw_ni` is still sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low |
| sel_a_ni | input | 1 | Chip enable, active low |
| sel_b_i | input | 1 | Chip enable, active high |
| sel_c_ni | input | 1 | Chip enable, active low |
| adv_i | input | 1 | 0 = load new operation, 1 = continue burst |
| we_ni | input | 1 | 0 = write, 1 = read (load cycles only) |
| bw_ni | input | 2 | Per-lane write enables, active low |
| addr_i | input | 6 | Word address |
| wdata_i | input | 18 | Write data, two enabled edges after its address |
| rdata_o | output | 18 | Registered read data |
| valid_o | output | 1 | High while `rdata_o` carries data of a selected read |

## Verification
Two events can fall on the same edge: a pending write commits to the array while the array is read for the operation loaded just after it. The bench provokes this with back-to-back write-then-read pairs to the same address. Some pairs use partial lane enables, and some are separated by clock-enable stalls. A behavioural reference model applies each write before serving the read that is due on the same edge. It judges every cycle's `valid_o` and `rdata_o` against that merged result.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/zbt_cmd_ctrl.sv
module zbt_cmd_ctrl
  import zbt_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 2,
  parameter int BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              adv_i,
  input  logic              we_ni,
  input  logic              sel_a_ni,
  input  logic              sel_b_i,
  input  logic              sel_c_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  bw_ni,
  output op_e               s1_op_o,
  output logic [ADDR_W-1:0] s1_addr_o,
  output op_e               s2_op_o,
  output logic [ADDR_W-1:0] s2_addr_o,
  output logic [LANES-1:0]  s2_bw_no
);

  op_e               s1_op_q, s2_op_q, nx_op;
  logic [ADDR_W-1:0] s1_addr_q, s2_addr_q, nx_addr;
  logic [LANES-1:0]  s1_bw_q, s2_bw_q;
  logic [BURST_W-1:0] burst_nx;
  logic              sel_ok;

  assign sel_ok   = !sel_a_ni && sel_b_i && !sel_c_ni;
  assign burst_nx = s1_addr_q[BURST_W-1:0] + 1'b1;

  // burst continues from the operation held in stage 1
  always_comb begin
    if (!adv_i) begin
      nx_addr = addr_i;
      nx_op   = sel_ok ? (we_ni ? OP_RD : OP_WR) : OP_IDLE;
    end else begin
      nx_addr = {s1_addr_q[ADDR_W-1:BURST_W], burst_nx};
      nx_op   = s1_op_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_op_q   <= OP_IDLE;
      s1_addr_q <= '0;
      s1_bw_q   <= '1;
      s2_op_q   <= OP_IDLE;
      s2_addr_q <= '0;
      s2_bw_q   <= '1;
    end else if (en_i) begin
      s1_op_q   <= nx_op;
      s1_addr_q <= nx_addr;
      s1_bw_q   <= bw_ni;
      s2_op_q   <= s1_op_q;
      s2_addr_q <= s1_addr_q;
      s2_bw_q   <= s1_bw_q;
    end
  end

  assign s1_op_o   = s1_op_q;
  assign s1_addr_o = s1_addr_q;
  assign s2_op_o   = s2_op_q;
  assign s2_addr_o = s2_addr_q;
  assign s2_bw_no  = s2_bw_q;

  a_r8_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !adv_i && (sel_a_ni || !sel_b_i || sel_c_ni) |=> s1_op_q == OP_IDLE);

  a_r9_burst_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && adv_i |=> s1_addr_q[BURST_W-1:0] == $past(s1_addr_q[BURST_W-1:0]) + 2'd1);

  a_r9_burst_high_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && adv_i |=> s1_addr_q[ADDR_W-1:BURST_W] == $past(s1_addr_q[ADDR_W-1:BURST_W]));

  a_r9_burst_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && adv_i |=> s1_op_q == $past(s1_op_q));

  a_r5_pipe_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> s2_op_q == $past(s1_op_q) && s2_addr_q == $past(s1_addr_q));

  a_r7_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(s1_op_q) && $stable(s2_op_q) && $stable(s1_addr_q));

endmodule

// File: rtl/zbt_byte_array.sv
module zbt_byte_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [LANES-1:0]        wr_bw_ni,
  input  logic [LANES*LANE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [LANES*LANE_W-1:0] rd_data_o
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_en_i && !wr_bw_ni[l]) mem_q[wr_addr_i] <= wr_data_i[l*LANE_W +: LANE_W];
    end

    assign rd_data_o[l*LANE_W +: LANE_W] = mem_q[rd_addr_i];
  end

endmodule

// File: rtl/zbt_rd_path.sv
module zbt_rd_path
  import zbt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  op_e                     s1_op_i,
  input  logic [ADDR_W-1:0]       s1_addr_i,
  input  op_e                     s2_op_i,
  input  logic [ADDR_W-1:0]       s2_addr_i,
  input  logic [LANES-1:0]        s2_bw_ni,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [LANES*LANE_W-1:0] arr_data_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    valid_o
);

  logic [LANES*LANE_W-1:0] fwd_data, rdata_q;
  logic                    valid_q, hit;

  // write committing on this edge has not reached the array yet
  assign hit = (s2_op_i == OP_WR) && (s2_addr_i == s1_addr_i);

  always_comb begin
    fwd_data = arr_data_i;
    for (int l = 0; l < LANES; l++) begin
      if (hit && !s2_bw_ni[l]) fwd_data[l*LANE_W +: LANE_W] = wdata_i[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      valid_q <= 1'b0;
    end else if (en_i) begin
      valid_q <= (s1_op_i == OP_RD);
      if (s1_op_i == OP_RD) rdata_q <= fwd_data;
    end
  end

  assign rdata_o = rdata_q;
  assign valid_o = valid_q;

  a_r6_fwd_lane0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && s1_op_i == OP_RD && s2_op_i == OP_WR && s2_addr_i == s1_addr_i && !s2_bw_ni[0]
    |=> rdata_o[LANE_W-1:0] == $past(wdata_i[LANE_W-1:0]));

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cke_ni,
  input  logic                    sel_a_ni,
  input  logic                    sel_b_i,
  input  logic                    sel_c_ni,
  input  logic                    adv_i,
  input  logic                    we_ni,
  input  logic [LANES-1:0]        bw_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    valid_o
);

  localparam int DATA_W = LANES * LANE_W;

  logic              en;
  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s2_bw_n;
  logic [DATA_W-1:0] arr_data;

  assign en = !cke_ni;

  zbt_cmd_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk_i, .rst_ni, .en_i(en), .adv_i, .we_ni,
    .sel_a_ni, .sel_b_i, .sel_c_ni, .addr_i, .bw_ni,
    .s1_op_o(s1_op), .s1_addr_o(s1_addr),
    .s2_op_o(s2_op), .s2_addr_o(s2_addr), .s2_bw_no(s2_bw_n)
  );

  zbt_byte_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i,
    .wr_en_i(en && s2_op == OP_WR),
    .wr_addr_i(s2_addr), .wr_bw_ni(s2_bw_n), .wr_data_i(wdata_i),
    .rd_addr_i(s1_addr), .rd_data_o(arr_data)
  );

  zbt_rd_path #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_rd (
    .clk_i, .rst_ni, .en_i(en),
    .s1_op_i(s1_op), .s1_addr_i(s1_addr),
    .s2_op_i(s2_op), .s2_addr_i(s2_addr), .s2_bw_ni(s2_bw_n),
    .wdata_i, .arr_data_i(arr_data),
    .rdata_o, .valid_o
  );

  a_r2_valid_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && s1_op == OP_RD |=> valid_o);

  a_r2_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && s1_op != OP_RD |=> !valid_o);

  a_r7_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> $stable(valid_o) && $stable(rdata_o));

endmodule

// File: tb/tb_zbt_sram.sv
`timescale 1ns/1ps
module tb_zbt_sram;
  localparam logic [2:0] CS_ON  = 3'b010; // {c_n, b, a_n}
  localparam logic [2:0] CS_XA  = 3'b011;
  localparam logic [2:0] CS_XB  = 3'b000;
  localparam logic [2:0] CS_XC  = 3'b110;

  logic        clk_i = 0, rst_ni = 0, cke_ni = 0;
  logic        sel_a_ni = 1, sel_b_i = 0, sel_c_ni = 1;
  logic        adv_i = 0, we_ni = 1;
  logic [1:0]  bw_ni = 2'b11;
  logic [5:0]  addr_i = 0;
  logic [17:0] wdata_i = 0;
  logic [17:0] rdata_o;
  logic        valid_o;

  zbt_sram dut (.*);

  always #4 clk_i = ~clk_i;

  int checks = 0, failures = 0;
  string cur_req = "R1";
  bit run_chk = 0;

  // reference model state
  logic [17:0] ref_mem [64];
  int          q1_op, q2_op;      // 0 idle, 1 read, 2 write
  logic [5:0]  q1_addr, q2_addr;
  logic [1:0]  q1_bw, q2_bw;
  logic        exp_valid;
  logic [17:0] exp_data;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q1_op = 0; q2_op = 0; q1_addr = 0; q2_addr = 0; q1_bw = 2'b11; q2_bw = 2'b11;
      exp_valid = 0; exp_data = 0;
    end else if (!cke_ni) begin
      int nop; logic [5:0] na;
      if (q2_op == 2) begin
        for (int l = 0; l < 2; l++)
          if (!q2_bw[l]) ref_mem[q2_addr][l*9 +: 9] = wdata_i[l*9 +: 9];
      end
      if (q1_op == 1) begin exp_valid = 1; exp_data = ref_mem[q1_addr]; end
      else exp_valid = 0;
      if (!adv_i) begin
        na  = addr_i;
        nop = (!sel_a_ni && sel_b_i && !sel_c_ni) ? (we_ni ? 1 : 2) : 0;
      end else begin
        nop = q1_op;
        na  = {q1_addr[5:2], 2'(q1_addr[1:0] + 2'd1)};
      end
      q2_op = q1_op; q2_addr = q1_addr; q2_bw = q1_bw;
      q1_op = nop;   q1_addr = na;      q1_bw = bw_ni;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && run_chk) begin
      checks++;
      if (valid_o !== exp_valid) begin
        failures++;
        $display("FAIL %s valid_o act=%0b exp=%0b t=%0t", cur_req, valid_o, exp_valid, $time);
      end
      if (exp_valid) begin
        checks++;
        if (rdata_o !== exp_data) begin
          failures++;
          $display("FAIL %s rdata_o act=%h exp=%h t=%0t", cur_req, rdata_o, exp_data, $time);
        end
      end
    end
  end

  logic [17:0] hist0 = 0, hist1 = 0;

  task automatic op(input logic adv, input logic we_n, input logic [2:0] cs,
                    input logic [5:0] a, input logic [1:0] bw, input logic [17:0] d);
    @(negedge clk_i);
    cke_ni = 0; adv_i = adv; we_ni = we_n;
    {sel_c_ni, sel_b_i, sel_a_ni} = cs;
    addr_i = a; bw_ni = bw;
    wdata_i = hist1; hist1 = hist0; hist0 = d;
  endtask

  task automatic stall();
    @(negedge clk_i);
    cke_ni = 1; adv_i = $urandom; we_ni = $urandom;
    {sel_c_ni, sel_b_i, sel_a_ni} = 3'($urandom);
    addr_i = 6'($urandom); bw_ni = 2'($urandom); wdata_i = 18'($urandom);
  endtask

  task automatic flush();
    op(0, 1, CS_XA, 0, 2'b11, 0);
    op(0, 1, CS_XA, 0, 2'b11, 0);
  endtask

  function automatic logic [17:0] fill_val(input int a);
    return 18'((a * 1237 + 4321) & 18'h3FFFF);
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    checks++;
    if (valid_o !== 0 || rdata_o !== 0) begin
      failures++;
      $display("FAIL R1 reset outputs act=%0b/%h exp=0/0", valid_o, rdata_o);
    end
    run_chk = 1;

    cur_req = "R3";
    for (int a = 0; a < 64; a++) op(0, 0, CS_ON, 6'(a), 2'b00, fill_val(a));
    flush();

    cur_req = "R2";
    for (int a = 0; a < 64; a += 7) op(0, 1, CS_ON, 6'(a), 2'b11, 0);
    flush();

    cur_req = "R4";
    op(0, 0, CS_ON, 6'd5, 2'b10, 18'h3ABCD);
    op(0, 0, CS_ON, 6'd6, 2'b01, 18'h15555);
    flush();
    op(0, 1, CS_ON, 6'd5, 2'b11, 0);
    op(0, 1, CS_ON, 6'd6, 2'b11, 0);
    flush();

    cur_req = "R5";
    for (int i = 0; i < 12; i++) begin
      op(0, 0, CS_ON, 6'(20 + i), 2'b00, 18'(i * 3001 + 7));
      op(0, 1, CS_ON, 6'(40 - i), 2'b11, 0);
    end
    flush();

    cur_req = "R6";
    op(0, 0, CS_ON, 6'd9, 2'b00, 18'h2F0F0);
    op(0, 1, CS_ON, 6'd9, 2'b11, 0);
    op(0, 0, CS_ON, 6'd10, 2'b10, 18'h01111);
    op(0, 1, CS_ON, 6'd10, 2'b11, 0);
    op(0, 0, CS_ON, 6'd11, 2'b01, 18'h3EEEE);
    op(0, 1, CS_ON, 6'd11, 2'b11, 0);
    op(0, 1, CS_ON, 6'd11, 2'b11, 0);
    flush();

    cur_req = "R7";
    op(0, 0, CS_ON, 6'd12, 2'b00, 18'h12345);
    stall(); stall();
    op(0, 1, CS_ON, 6'd12, 2'b11, 0);
    stall();
    op(0, 1, CS_ON, 6'd13, 2'b11, 0);
    stall(); stall(); stall();
    flush();

    cur_req = "R8";
    op(0, 0, CS_XA, 6'd14, 2'b00, 18'h00001);
    op(0, 0, CS_XB, 6'd15, 2'b00, 18'h00002);
    op(0, 0, CS_XC, 6'd16, 2'b00, 18'h00003);
    op(0, 1, CS_XB, 6'd14, 2'b11, 0);
    flush();
    op(0, 1, CS_ON, 6'd14, 2'b11, 0);
    op(0, 1, CS_ON, 6'd15, 2'b11, 0);
    op(0, 1, CS_ON, 6'd16, 2'b11, 0);
    flush();

    cur_req = "R9";
    op(0, 1, CS_ON, 6'd34, 2'b11, 0);
    op(1, 0, CS_XA, 6'd0, 2'b11, 0);
    op(1, 0, CS_XB, 6'd63, 2'b11, 0);
    op(1, 0, CS_XC, 6'd7, 2'b11, 0);
    op(0, 0, CS_ON, 6'd47, 2'b00, 18'h2AAAA);
    op(1, 1, CS_XA, 6'd0, 2'b01, 18'h15151);
    op(1, 1, CS_XB, 6'd1, 2'b00, 18'h0C3C3);
    op(0, 0, CS_XA, 6'd50, 2'b00, 0);
    op(1, 0, CS_ON, 6'd50, 2'b00, 18'h3FFFF);
    flush();
    op(0, 1, CS_ON, 6'd44, 2'b11, 0);
    op(1, 1, CS_ON, 6'd44, 2'b11, 0);
    op(1, 1, CS_ON, 6'd44, 2'b11, 0);
    op(1, 1, CS_ON, 6'd44, 2'b11, 0);
    op(0, 1, CS_ON, 6'd50, 2'b11, 0);
    op(0, 1, CS_ON, 6'd51, 2'b11, 0);
    flush();
    flush();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule